// File: doc/BRIEF.md
# Inbound Memory-Write Posting Buffer

This block sits behind the target side of a PCI host bridge and absorbs memory-write bursts from bus masters that are aimed at main memory. Each accepted data phase goes into a small ring of cache-line entries. An entry holds the line address, one data word for each longword of the line, and a byte-enable group for each word. A downstream memory writer drains the entries one at a time through a ready/valid handshake, in the order the entries were filled.

The ingress side is a simplified target data phase. A valid strobe qualifies the address, the 32-bit data, the byte enables and a last flag. The address counts only on the first phase of a burst. After that the block advances through the line by itself. The block answers with two combinational signals in the same cycle as the phase. Retry means the phase was refused. Disconnect means this phase is taken and it is the final one the block will take.

A burst may run into a second cache line only when the two lines form one 64-byte aligned block. A burst that starts on a 64-byte boundary can therefore carry 16 longwords. Any other start stops at the end of its own 64-byte block.

Top module: `wpost_buf`

## Requirements
- R1: The buffer holds DEPTH (4) committed entries. With the drain side stalled, four single-line bursts are all kept and presented in turn afterwards.
- R2: An entry is presented as out_addr, out_data and out_be. out_addr is the line base address with bits 4:0 zero. Longword i sits at out_data[32i+31:32i], and its byte enables sit at out_be[4i+3:4i].
- R3: A burst whose first address has bits 5:2 all zero may take 16 longwords across two consecutive entries. in_disc is high together with the 16th phase.
- R4: A burst whose first address has bit 5 = 0 and word index w = bits 4:2 nonzero is disconnected on its (16 − w)-th phase.
- R5: A burst whose first address has bit 5 = 1 and word index w is disconnected on its (8 − w)-th phase.
- R6: When all DEPTH entries are committed and no burst is in progress, a valid phase sees in_retry high and is not accepted.
- R7: A burst reaches the last word of a line with address bit 5 = 0. If fewer than two entries are then free (more than DEPTH − 2 committed), in_disc is raised on that phase and the burst ends there.
- R8: A phase with in_last ends the burst and commits a partial entry. Longwords of an entry that were never written carry byte enables of zero.
- R9: Entries leave in fill order. out_valid and the entry's contents stay unchanged until out_ready is seen high. An entry is removed on the cycle of the handshake.
- R10: in_addr is ignored on every phase of a burst except the first.
- R11: in_retry and in_disc are low whenever in_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Data phase present |
| in_addr | input | 32 | Byte address, sampled on the first phase of a burst |
| in_data | input | 32 | Longword data |
| in_be | input | 4 | Byte enables of the longword |
| in_last | input | 1 | Initiator's final phase |
| in_retry | output | 1 | Phase refused, no free entry |
| in_disc | output | 1 | Phase accepted, and the burst ends here |
| out_valid | output | 1 | Entry presented downstream |
| out_ready | input | 1 | Downstream accepts the entry |
| out_addr | output | 32 | Line base address |
| out_data | output | 256 | Eight longwords of the entry |
| out_be | output | 32 | Byte enables, four for each longword |

## Verification
The bench drives bursts from every kind of start: aligned on 64 bytes, inside the first half of a block, and inside the second half. It compares the phase count at which the burst is cut with the figure the rules give. A design that tested only bit 5, or only bits 4:2, would cut too early or let a burst spill into a third line. A full buffer is tested both at burst start and at a line crossing. Leaving out either check would overwrite a committed entry, and the reference queue would then see a lost or garbled line. Partial bursts with sparse byte enables, garbage addresses on later phases, and a randomly stalled drain side expose stale byte enables, address resampling and entries that change while they wait.

// File: rtl/wpost_pkg.sv
package wpost_pkg;

   typedef enum logic [0:0] {
      PH_IDLE  = 1'b0,
      PH_BURST = 1'b1
   } burst_ph_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/wpost_slots.sv
module wpost_slots #(
   parameter int DEPTH = 4,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             out_ready,
   output logic [PTR_W-1:0] wr_ptr,
   output logic [PTR_W-1:0] rd_ptr,
   output logic [CNT_W-1:0] occ,
   output logic             out_valid
);

   logic [DEPTH-1:0] valid_q;
   logic             pop;

   assign out_valid = valid_q[rd_ptr];
   assign pop       = out_valid && out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         occ     <= '0;
      end else begin
         if (push) begin
            valid_q[wr_ptr] <= 1'b1;
            wr_ptr          <= wr_ptr + PTR_W'(1);
         end
         if (pop) begin
            valid_q[rd_ptr] <= 1'b0;
            rd_ptr          <= rd_ptr + PTR_W'(1);
         end
         occ <= occ + CNT_W'(push) - CNT_W'(pop);
      end
   end

   // R1: a commit never lands on a slot still holding an undrained entry
   p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !valid_q[wr_ptr]);

   // R1: occupancy counter agrees with the per-slot valid bits
   p_occ_track_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(valid_q) == int'(occ));

endmodule

// File: rtl/wpost_store.sv
module wpost_store #(
   parameter int DEPTH      = 4,
   parameter int LINE_W     = 27,
   parameter int DATA_W     = 32,
   parameter int LINE_WORDS = 8,
   localparam int PTR_W  = $clog2(DEPTH),
   localparam int BE_W   = DATA_W / 8,
   localparam int WIDX_W = $clog2(LINE_WORDS)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [PTR_W-1:0]             wr_ptr,
   input  logic                         wr_first,
   input  logic [WIDX_W-1:0]            wr_widx,
   input  logic [LINE_W-1:0]            wr_line,
   input  logic [DATA_W-1:0]            wr_data,
   input  logic [BE_W-1:0]              wr_be,
   input  logic [PTR_W-1:0]             rd_ptr,
   output logic [LINE_W-1:0]            rd_line,
   output logic [LINE_WORDS*DATA_W-1:0] rd_data,
   output logic [LINE_WORDS*BE_W-1:0]   rd_be
);

   logic [LINE_W-1:0]                      line_a [DEPTH];
   logic [LINE_WORDS-1:0][DATA_W-1:0]      dat_a  [DEPTH];
   logic [LINE_WORDS-1:0][BE_W-1:0]        be_a   [DEPTH];

   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      logic                              hit;
      logic [LINE_W-1:0]                 line_q;
      logic [LINE_WORDS-1:0][DATA_W-1:0] dat_q;
      logic [LINE_WORDS-1:0][BE_W-1:0]   be_q;

      assign hit = wr_en && (wr_ptr == PTR_W'(s));

      always_ff @(posedge clk) begin
         if (hit) line_q <= wr_line;
      end

      for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
         always_ff @(posedge clk) begin
            if (hit && (wr_widx == WIDX_W'(w))) dat_q[w] <= wr_data;
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               be_q[w] <= '0;
            end else if (hit) begin
               if (wr_widx == WIDX_W'(w)) be_q[w] <= wr_be;
               else if (wr_first)         be_q[w] <= '0;
            end
         end
      end

      assign line_a[s] = line_q;
      assign dat_a[s]  = dat_q;
      assign be_a[s]   = be_q;
   end

   assign rd_line = line_a[rd_ptr];
   assign rd_data = dat_a[rd_ptr];
   assign rd_be   = be_a[rd_ptr];

endmodule

// File: rtl/wpost_burst_ctl.sv
module wpost_burst_ctl
   import wpost_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int LINE_WORDS = 8,
   parameter int DEPTH      = 4,
   localparam int BE_W   = DATA_W / 8,
   localparam int BSH    = $clog2(BE_W),
   localparam int WIDX_W = $clog2(LINE_WORDS),
   localparam int OFS_W  = BSH + WIDX_W,
   localparam int LINE_W = ADDR_W - OFS_W,
   localparam int CNT_W  = $clog2(DEPTH + 1),
   localparam int BEAT_W = $clog2(2 * LINE_WORDS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic              in_last,
   input  logic [CNT_W-1:0]  occ,
   output logic              in_retry,
   output logic              in_disc,
   output logic              wr_en,
   output logic              wr_first,
   output logic [WIDX_W-1:0] wr_widx,
   output logic [LINE_W-1:0] wr_line,
   output logic              push
);

   burst_ph_e         ph_q;
   logic [LINE_W-1:0] line_q;
   logic [WIDX_W-1:0] widx_q;

   logic              in_burst;
   logic [LINE_W-1:0] ph_line;
   logic [WIDX_W-1:0] ph_widx;
   logic              accept, line_end, room2, done;

   assign in_burst = (ph_q == PH_BURST);
   assign ph_line  = in_burst ? line_q : in_addr[ADDR_W-1:OFS_W];
   assign ph_widx  = in_burst ? widx_q : in_addr[OFS_W-1:BSH];

   assign in_retry = in_valid && !in_burst && (occ == CNT_W'(DEPTH));
   assign accept   = in_valid && !in_retry;
   assign line_end = (ph_widx == WIDX_W'(LINE_WORDS - 1));
   assign room2    = (occ <= CNT_W'(DEPTH - 2));
   // second line of an aligned pair, or no room to open another entry
   assign in_disc  = accept && line_end && (ph_line[0] || !room2);
   assign done     = accept && (in_last || in_disc);

   assign wr_en    = accept;
   assign wr_first = !in_burst || (widx_q == '0);
   assign wr_widx  = ph_widx;
   assign wr_line  = ph_line;
   assign push     = accept && (done || line_end);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         line_q <= '0;
         widx_q <= '0;
      end else if (accept) begin
         ph_q <= done ? PH_IDLE : PH_BURST;
         if (line_end) begin
            line_q <= ph_line + LINE_W'(1);
            widx_q <= '0;
         end else begin
            line_q <= ph_line;
            widx_q <= ph_widx + WIDX_W'(1);
         end
      end
   end

   // beat counter kept for checking the burst limit only
   logic [BEAT_W-1:0] beats_q;
   always_ff @(posedge clk) begin
      if (!rst_n)      beats_q <= '0;
      else if (accept) beats_q <= in_burst ? beats_q + BEAT_W'(1) : BEAT_W'(1);
   end

   // R3: an open burst has always taken fewer than two full lines
   p_beat_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      in_burst |-> (beats_q < BEAT_W'(2 * LINE_WORDS)));

   // R4: a disconnected phase leaves the controller idle
   p_disc_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
      in_disc |=> !in_burst);

   // R7: a line crossing only happens with an entry left for the next line
   p_cross_room_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && line_end && !done) |-> room2);

endmodule

// File: rtl/wpost_buf.sv
module wpost_buf
   import wpost_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int LINE_WORDS = 8,
   parameter int DEPTH      = 4,
   localparam int BE_W   = DATA_W / 8,
   localparam int WIDX_W = $clog2(LINE_WORDS),
   localparam int OFS_W  = $clog2(BE_W) + WIDX_W,
   localparam int LINE_W = ADDR_W - OFS_W,
   localparam int PTR_W  = $clog2(DEPTH),
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         in_valid,
   input  logic [ADDR_W-1:0]            in_addr,
   input  logic [DATA_W-1:0]            in_data,
   input  logic [BE_W-1:0]              in_be,
   input  logic                         in_last,
   output logic                         in_retry,
   output logic                         in_disc,
   output logic                         out_valid,
   input  logic                         out_ready,
   output logic [ADDR_W-1:0]            out_addr,
   output logic [LINE_WORDS*DATA_W-1:0] out_data,
   output logic [LINE_WORDS*BE_W-1:0]   out_be
);

   initial begin : elab_checks
      assert (is_pow2(DEPTH) && DEPTH >= 2) else $fatal(1, "DEPTH must be a power of two, at least 2");
      assert (is_pow2(LINE_WORDS) && LINE_WORDS >= 2) else $fatal(1, "LINE_WORDS must be a power of two, at least 2");
      assert (DATA_W >= 8 && is_pow2(DATA_W / 8) && DATA_W % 8 == 0) else $fatal(1, "DATA_W must be a power-of-two byte count");
      assert (ADDR_W > OFS_W + 1) else $fatal(1, "ADDR_W too narrow for the line size");
   end

   logic              wr_en, wr_first, push;
   logic [WIDX_W-1:0] wr_widx;
   logic [LINE_W-1:0] wr_line, rd_line;
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic [CNT_W-1:0]  occ;

   wpost_burst_ctl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS), .DEPTH(DEPTH)
   ) u_ctl (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
      .in_last(in_last), .occ(occ), .in_retry(in_retry), .in_disc(in_disc),
      .wr_en(wr_en), .wr_first(wr_first), .wr_widx(wr_widx),
      .wr_line(wr_line), .push(push)
   );

   wpost_slots #(.DEPTH(DEPTH)) u_slots (
      .clk(clk), .rst_n(rst_n), .push(push), .out_ready(out_ready),
      .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .occ(occ), .out_valid(out_valid)
   );

   wpost_store #(
      .DEPTH(DEPTH), .LINE_W(LINE_W), .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ptr(wr_ptr),
      .wr_first(wr_first), .wr_widx(wr_widx), .wr_line(wr_line),
      .wr_data(in_data), .wr_be(in_be), .rd_ptr(rd_ptr),
      .rd_line(rd_line), .rd_data(out_data), .rd_be(out_be)
   );

   assign out_addr = {rd_line, {OFS_W{1'b0}}};

   // R9: a presented entry holds until the handshake
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_be)));

   // R6: retry is only given when every entry is committed
   p_retry_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      in_retry |-> (occ == CNT_W'(DEPTH)));

   // R11: no target response without a data phase
   p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> (!in_retry && !in_disc));

endmodule

// File: tb/sim_wpost_buf.sv
`timescale 1ns/1ps
module sim_wpost_buf;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         in_valid, in_last, out_ready;
   logic [31:0]  in_addr, in_data;
   logic [3:0]   in_be;
   logic         in_retry, in_disc, out_valid;
   logic [31:0]  out_addr;
   logic [255:0] out_data;
   logic [31:0]  out_be;

   always #2.5 clk = ~clk;

   wpost_buf u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
      .in_data(in_data), .in_be(in_be), .in_last(in_last),
      .in_retry(in_retry), .in_disc(in_disc), .out_valid(out_valid),
      .out_ready(out_ready), .out_addr(out_addr), .out_data(out_data),
      .out_be(out_be)
   );

   int total = 0;
   int bad   = 0;

   task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference
   typedef struct {
      logic [31:0] addr;
      logic [31:0] d [8];
      logic [3:0]  be [8];
   } ent_t;

   ent_t        q[$];
   ent_t        cur;
   bit          m_active = 0;
   logic [26:0] m_line;
   logic [2:0]  m_widx;
   int          rdy_mode = 1;
   bit          obs_retry, obs_disc;

   task automatic step();
      int          cnt;
      bit          e_retry, e_disc, acc, popped;
      logic [26:0] pl;
      logic [2:0]  pw;
      if (rdy_mode == 2) out_ready = 1'($urandom % 2);
      else               out_ready = 1'(rdy_mode);
      #1;
      cnt     = q.size();
      e_retry = in_valid && !m_active && (cnt == 4);
      acc     = in_valid && !e_retry;
      pl      = m_active ? m_line : in_addr[31:5];   // R10: later addresses unused
      pw      = m_active ? m_widx : in_addr[4:2];
      e_disc  = acc && (pw == 3'd7) && (pl[0] || cnt > 2);
      obs_retry = in_retry;
      obs_disc  = in_disc;
      chk(in_retry == e_retry, "R6/R11 retry", 256'(in_retry), 256'(e_retry));
      chk(in_disc == e_disc, "R3/R4/R5/R7/R11 disconnect", 256'(in_disc), 256'(e_disc));
      chk(out_valid == (cnt > 0), "R1/R9 out_valid", 256'(out_valid), 256'(cnt > 0));
      if (cnt > 0 && out_valid) begin
         chk(out_addr == q[0].addr, "R2/R9 out_addr", 256'(out_addr), 256'(q[0].addr));
         for (int i = 0; i < 8; i++) begin
            chk(out_be[4*i +: 4] == q[0].be[i], "R2/R8 out_be word", 256'(out_be[4*i +: 4]), 256'(q[0].be[i]));
            if (q[0].be[i] != 4'h0)
               chk(out_data[32*i +: 32] == q[0].d[i], "R2 out_data word", 256'(out_data[32*i +: 32]), 256'(q[0].d[i]));
         end
      end
      popped = (cnt > 0) && out_ready;
      @(posedge clk);
      if (popped) void'(q.pop_front());
      if (acc) begin
         if (!m_active || pw == 3'd0) begin
            cur.addr = {pl, 5'b0};
            for (int i = 0; i < 8; i++) begin
               cur.be[i] = 4'h0;
               cur.d[i]  = 32'h0;
            end
         end
         cur.d[pw]  = in_data;
         cur.be[pw] = in_be;
         if (in_last || e_disc || pw == 3'd7) q.push_back(cur);
         m_active = !(in_last || e_disc);
         if (pw == 3'd7) begin
            m_line = pl + 27'd1;
            m_widx = 3'd0;
         end else begin
            m_line = pl;
            m_widx = pw + 3'd1;
         end
      end
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      in_valid = 1'b0;
      in_last  = 1'b0;
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic burst(input logic [31:0] a, input int n, input logic [3:0] be, output int took);
      took = 0;
      for (int k = 0; k < n; k++) begin
         in_valid = 1'b1;
         in_addr  = (k == 0) ? a : (32'hBAD0_0000 ^ 32'(k * 4099));  // R10
         in_data  = {a[19:4], 16'(k)} ^ $urandom;
         in_be    = be;
         in_last  = (k == n - 1);
         step();
         if (obs_retry) break;
         took++;
         if (obs_disc) break;
      end
      in_valid = 1'b0;
      in_last  = 1'b0;
   endtask

   task automatic drain();
      rdy_mode = 1;
      idle(6);
   endtask

   initial begin : watchdog
      #(200000 * 5);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      int took;
      in_valid = 0; in_last = 0; in_addr = 0; in_data = 0; in_be = 0;
      out_ready = 0;
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(!out_valid && !in_retry && !in_disc, "R1 reset state", 256'({out_valid, in_retry, in_disc}), 256'(0));
      @(negedge clk);

      // R3: aligned start, 16 longwords over two entries
      rdy_mode = 0;
      burst(32'h0000_1000, 20, 4'hF, took);
      chk(took == 16, "R3 aligned burst length", 256'(took), 256'(16));

      // R4: bit5 clear, word 3 -> 13 phases
      burst(32'h2000_000C, 20, 4'hF, took);
      chk(took == 13, "R4 unaligned low-half length", 256'(took), 256'(13));

      // R6 / R1: four committed entries, next start is refused
      burst(32'h3000_0000, 4, 4'hF, took);
      chk(took == 0, "R6 no phase accepted when full", 256'(took), 256'(0));
      chk(obs_retry, "R6 retry seen", 256'(obs_retry), 256'(1));
      idle(3);
      chk(q.size() == 4 && out_valid, "R1 four entries held", 256'(out_valid), 256'(1));

      // R9: drain in order under the model
      drain();

      // R5: bit5 set, word 2 -> 6 phases
      burst(32'h3000_0028, 10, 4'hF, took);
      chk(took == 6, "R5 upper-half length", 256'(took), 256'(6));

      // R8: short burst, sparse enables
      burst(32'h4000_0008, 3, 4'b0101, took);
      chk(took == 3, "R8 last ends burst", 256'(took), 256'(3));
      drain();

      // R7: three entries committed, aligned start cannot cross
      rdy_mode = 0;
      burst(32'h5000_0100, 1, 4'hF, took);
      burst(32'h5000_0204, 1, 4'h3, took);
      burst(32'h5000_0318, 1, 4'h8, took);
      burst(32'h6000_0000, 16, 4'hF, took);
      chk(took == 8, "R7 crossing blocked by space", 256'(took), 256'(8));
      idle(2);
      drain();

      // R9: drain stalls at random, mixed bursts
      rdy_mode = 2;
      for (int b = 0; b < 40; b++) begin
         burst($urandom & 32'hFFFF_FFFC, 1 + int'($urandom % 18), 4'($urandom), took);
         idle(int'($urandom % 3));
      end
      drain();
      idle(4);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule